// File: doc/BRIEF.md
# Serial configuration bitstream reader

This block is the read side of a bit-serial configuration store that feeds a programmable logic device while it loads. A one-bit-wide array sits behind an address pointer. On each rising edge of the configuration clock the pointer steps forward and the next stored bit appears on the serial data output. Stepping only happens when the combined clear/enable input is high, the active-low select is low, the serial-enable input is high, power-up has finished, and the stored data has not all been sent.

When the last bit has gone out, the active-low cascade output asserts. This output is wired to the select input of the next unit, so several units can form a chain. The select level seen while the clear/enable input is held low records whether the unit heads the chain. A ready flag stays low for a fixed number of system clocks after power-on reset. While serial-enable is low, a parallel preload port writes single array bits. The configuration clock is an input that is synchronous to the system clock, and its rising edges are detected in the system-clock domain. Instead of a tri-state pin, the data output comes with a separate enable.

Top module: `cfgrom_reader`

## Requirements
- R1: After `rst`, `ready` stays 0 for exactly PWR_CYCLES rising `clk` edges with `rst` low. It rises at the PWR_CYCLES-th edge and then stays 1 until the next `rst`.
- R2: When `oe_rstn` is 0 at a `clk` edge, the pointer goes to 0 and `casc_n` goes to 1 at that edge. After `oe_rstn` returns high, `sdata` shows stored bit 0 again.
- R3: A configuration-clock rising edge is a `clk` edge at which `cfg_clk` is 1 and was 0 at the previous edge. If stepping is allowed at that edge, the pointer advances by one. At the same edge `sdata` becomes the stored bit at the new pointer, where 1 means a stored 1.
- R4: While `cs_n` is 1, the pointer does not move, and at the following edge `sdata_oe` is 0.
- R5: While `ser_en` is 0, the pointer does not move and `sdata_oe` is 0. A `pre_we` pulse in that state writes `pre_data` to address `pre_addr`.
- R6: A `pre_we` pulse while `ser_en` is 1 leaves the array unchanged.
- R7: A step taken at pointer DEPTH-1 sets `casc_n` to 0 and leaves the pointer at DEPTH-1. `casc_n` then stays 0, and no further step happens, until `oe_rstn` is low or `rst` is asserted.
- R8: `first_dev` takes the inverse of `cs_n` at every edge where `oe_rstn` is 0, and holds it while `oe_rstn` is 1. Its reset value is 0. A value of 1 means the unit heads the chain.
- R9: While `ready` is 0, configuration-clock edges do not move the pointer.
- R10: `sdata_oe` is registered. It is 1 exactly when, at the previous edge, `ready`, `ser_en` and `oe_rstn` were 1 and `cs_n` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_clk | input | 1 | Configuration clock level, synchronous to clk |
| oe_rstn | input | 1 | Low clears the pointer; high enables output and stepping |
| cs_n | input | 1 | Active-low select |
| ser_en | input | 1 | High: loading mode; low: preload mode |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | AW | Preload bit address |
| pre_data | input | 1 | Preload bit value |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Data output enable |
| casc_n | output | 1 | Active-low cascade, asserted when all data has been sent |
| first_dev | output | 1 | Unit heads the chain |
| ready | output | 1 | Power-up interval complete |

## Verification
If the pointer holds a wrong value, the serial output shows it on the very next enabled cycle, because `sdata` always mirrors the bit at the pointer. Using stored patterns in which neighbouring bits differ turns a skipped or extra step into a bit mismatch within one cycle. A wrong exhaustion flag shows as `casc_n` switching one step early or late. A wrong power-up count moves the `ready` edge. The reference model runs every cycle, so a mismatch is reported in the cycle in which it first reaches a port.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  // Width of a pointer that covers `depth` entries (at least one bit).
  function automatic int unsigned addr_w(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // Width of a counter that must reach `limit`.
  function automatic int unsigned cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  typedef enum logic {
    ROLE_LATER = 1'b0,
    ROLE_FIRST = 1'b1
  } chain_role_e;

endpackage

// File: rtl/cfgrom_pwrup.sv
module cfgrom_pwrup #(
  parameter int unsigned PWR_CYCLES = 64,
  localparam int unsigned CW = cfgrom_pkg::cnt_w(PWR_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);

  localparam logic [CW-1:0] LAST = CW'(PWR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt_q == LAST) begin
        ready <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgrom_bitmem.sv
module cfgrom_bitmem #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = cfgrom_pkg::addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = cfgrom_pkg::addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready,
  input  logic          cfg_clk,
  input  logic          oe_rstn,
  input  logic          cs_n,
  input  logic          ser_en,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_nxt,
  output logic          casc_n,
  output logic          first_dev,
  output logic          sdata_oe
);

  import cfgrom_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic        cfg_q;
  logic        done_q;
  logic        done_nxt;
  logic        rise;
  logic        step;
  chain_role_e role_q;

  assign rise = cfg_clk & ~cfg_q;
  assign step = ready & ser_en & oe_rstn & ~cs_n & ~done_q & rise;

  always_comb begin
    ptr_nxt  = ptr_q;
    done_nxt = done_q;
    if (rst || !oe_rstn) begin
      ptr_nxt  = '0;
      done_nxt = 1'b0;
    end else if (step) begin
      if (ptr_q == LAST) begin
        done_nxt = 1'b1;
      end else begin
        ptr_nxt = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= 1'b0;
      ptr_q    <= '0;
      done_q   <= 1'b0;
      casc_n   <= 1'b1;
      role_q   <= ROLE_LATER;
      sdata_oe <= 1'b0;
    end else begin
      cfg_q    <= cfg_clk;
      ptr_q    <= ptr_nxt;
      done_q   <= done_nxt;
      casc_n   <= ~done_nxt;
      sdata_oe <= ready & ser_en & oe_rstn & ~cs_n;
      if (!oe_rstn) begin
        role_q <= cs_n ? ROLE_LATER : ROLE_FIRST;
      end
    end
  end

  assign first_dev = (role_q == ROLE_FIRST);

endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader #(
  parameter int unsigned DEPTH      = 2048,
  parameter int unsigned PWR_CYCLES = 64,
  localparam int unsigned AW = cfgrom_pkg::addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_clk,
  input  logic          oe_rstn,
  input  logic          cs_n,
  input  logic          ser_en,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic          pre_data,
  output logic          sdata,
  output logic          sdata_oe,
  output logic          casc_n,
  output logic          first_dev,
  output logic          ready
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nxt;
  logic          wr_en;

  assign wr_en = pre_we & ~ser_en;

  cfgrom_pwrup #(
    .PWR_CYCLES(PWR_CYCLES)
  ) pwrup_i (
    .clk  (clk),
    .rst  (rst),
    .ready(ready)
  );

  cfgrom_seq #(
    .DEPTH(DEPTH)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .cfg_clk  (cfg_clk),
    .oe_rstn  (oe_rstn),
    .cs_n     (cs_n),
    .ser_en   (ser_en),
    .ptr_q    (ptr_q),
    .ptr_nxt  (ptr_nxt),
    .casc_n   (casc_n),
    .first_dev(first_dev),
    .sdata_oe (sdata_oe)
  );

  cfgrom_bitmem #(
    .DEPTH(DEPTH)
  ) mem_i (
    .clk  (clk),
    .we   (wr_en),
    .waddr(pre_addr),
    .wdata(pre_data),
    .raddr(ptr_nxt),
    .rdata(sdata)
  );

endmodule

// File: rtl/cfgrom_reader_chk.sv
module cfgrom_reader_chk #(
  parameter int unsigned AW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          oe_rstn,
  input logic          cs_n,
  input logic          ser_en,
  input logic          casc_n,
  input logic          sdata_oe,
  input logic [AW-1:0] ptr
);

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !oe_rstn |=> (ptr == '0 && casc_n));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    oe_rstn |=> (ptr == $past(ptr) || ptr == AW'($past(ptr) + 1'b1)));

  assert_hold_unselected_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && oe_rstn) |=> $stable(ptr));

  assert_hold_preload_R5: assert property (@(posedge clk) disable iff (rst)
    (!ser_en && oe_rstn) |=> $stable(ptr));

  assert_casc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!casc_n && oe_rstn) |=> (!casc_n && $stable(ptr)));

  assert_hold_powerup_R9: assert property (@(posedge clk) disable iff (rst)
    (!ready && oe_rstn) |=> $stable(ptr));

  assert_oe_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> ready);

endmodule

bind cfgrom_reader cfgrom_reader_chk #(
  .AW(AW)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ready   (ready),
  .oe_rstn (oe_rstn),
  .cs_n    (cs_n),
  .ser_en  (ser_en),
  .casc_n  (casc_n),
  .sdata_oe(sdata_oe),
  .ptr     (ptr_q)
);

// File: tb/cfgrom_reader_tb_top.sv
module cfgrom_reader_tb_top;

  localparam int DEPTH = 16;
  localparam int PWR   = 30;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_clk = 1'b0;
  logic          oe_rstn = 1'b0;
  logic          cs_n = 1'b0;
  logic          ser_en = 1'b0;
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic          pre_data = 1'b0;
  logic          sdata, sdata_oe, casc_n, first_dev, ready;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cfgrom_reader #(.DEPTH(DEPTH), .PWR_CYCLES(PWR)) dut_i (
    .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .oe_rstn(oe_rstn), .cs_n(cs_n),
    .ser_en(ser_en), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .sdata(sdata), .sdata_oe(sdata_oe), .casc_n(casc_n),
    .first_dev(first_dev), .ready(ready)
  );

  function automatic bit pat(input int i);
    return bit'(((i * 11 + 3) >> 2) & 1);
  endfunction

  // Behavioural reference model
  bit m_mem [DEPTH];
  int m_ptr = 0;
  int m_cnt = 0;
  bit m_done = 0, m_ready = 0, m_casc = 1, m_first = 0, m_oe = 0, m_cq = 0, m_sd = 0;

  always @(posedge clk) begin
    bit r_old;
    bit rise;
    r_old = m_ready;
    rise  = cfg_clk && !m_cq;
    if (rst) begin
      m_ptr = 0; m_done = 0; m_casc = 1; m_first = 0; m_oe = 0; m_cq = 0;
      m_cnt = 0; m_ready = 0;
    end else begin
      m_cq = cfg_clk;
      if (!m_ready) begin
        m_cnt++;
        if (m_cnt == PWR) m_ready = 1;
      end
      if (!oe_rstn) begin
        m_ptr = 0; m_done = 0; m_first = !cs_n;
      end else if (r_old && ser_en && !cs_n && !m_done && rise) begin
        if (m_ptr == DEPTH - 1) m_done = 1;
        else m_ptr++;
      end
      m_casc = !m_done;
      m_oe = r_old && ser_en && oe_rstn && !cs_n;
    end
    m_sd = m_mem[m_ptr];
    if (!rst && pre_we && !ser_en) m_mem[pre_addr] = pre_data;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "ready", int'(ready), int'(m_ready));
      chk("R7", "casc_n", int'(casc_n), int'(m_casc));
      chk("R8", "first_dev", int'(first_dev), int'(m_first));
      chk("R10", "sdata_oe", int'(sdata_oe), int'(m_oe));
      if (m_oe) chk("R3", "sdata", int'(sdata), int'(m_sd));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) cfg_clk = 1'b1;
      @(negedge clk) cfg_clk = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // reset state
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R7", "casc_n in reset", int'(casc_n), 1);
    chk("R10", "sdata_oe in reset", int'(sdata_oe), 0);
    rst = 1'b0;
    // R5: preload every bit while ser_en is low
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = pat(i);
    end
    @(negedge clk) pre_we = 1'b0;
    // R9: clock edges during power-up must not step
    ser_en = 1'b1; oe_rstn = 1'b1; cs_n = 1'b0;
    pulse(4);
    chk("R1", "ready before end of power-up", int'(ready), 0);
    wait (ready);
    idle(2);
    chk("R9", "sdata after power-up edges", int'(sdata), int'(pat(0)));
    chk("R9", "sdata_oe", int'(sdata_oe), 1);
    // R2: step then clear, head of chain
    pulse(3);
    chk("R3", "sdata after 3 steps", int'(sdata), int'(pat(3)));
    @(negedge clk) oe_rstn = 1'b0;
    idle(2);
    oe_rstn = 1'b1;
    idle(2);
    chk("R2", "sdata after clear", int'(sdata), int'(pat(0)));
    chk("R8", "first_dev head", int'(first_dev), 1);
    // R3: stream bits
    for (int k = 1; k <= 6; k++) begin
      pulse(1);
      chk("R3", "streamed bit", int'(sdata), int'(pat(k)));
    end
    // R4: deselected
    cs_n = 1'b1;
    pulse(3);
    chk("R4", "sdata_oe deselected", int'(sdata_oe), 0);
    cs_n = 1'b0;
    idle(2);
    chk("R4", "pointer held", int'(sdata), int'(pat(6)));
    // R5: programming mode holds the pointer
    ser_en = 1'b0;
    pulse(3);
    chk("R5", "sdata_oe in preload mode", int'(sdata_oe), 0);
    ser_en = 1'b1;
    idle(2);
    chk("R5", "pointer held", int'(sdata), int'(pat(6)));
    // R7: exhaust the array
    pulse(9);
    chk("R7", "casc_n before last step", int'(casc_n), 1);
    chk("R3", "last bit", int'(sdata), int'(pat(15)));
    pulse(1);
    chk("R7", "casc_n after last step", int'(casc_n), 0);
    pulse(3);
    chk("R7", "casc_n held", int'(casc_n), 0);
    chk("R7", "pointer stays at last", int'(sdata), int'(pat(15)));
    // R6: write ignored while ser_en is high
    @(negedge clk);
    pre_we = 1'b1; pre_addr = AW'(1); pre_data = !pat(1);
    @(negedge clk) pre_we = 1'b0;
    // R2 and R8: clear with cs_n high, later member of chain
    cs_n = 1'b1; oe_rstn = 1'b0;
    idle(2);
    oe_rstn = 1'b1;
    idle(1);
    chk("R2", "casc_n released", int'(casc_n), 1);
    chk("R8", "first_dev later", int'(first_dev), 0);
    cs_n = 1'b0;
    pulse(1);
    idle(1);
    chk("R6", "bit 1 unchanged", int'(sdata), int'(pat(1)));
    // R5: accepted write in preload mode
    ser_en = 1'b0;
    @(negedge clk);
    pre_we = 1'b1; pre_addr = AW'(0); pre_data = !pat(0);
    @(negedge clk) pre_we = 1'b0;
    oe_rstn = 1'b0;
    idle(2);
    oe_rstn = 1'b1; ser_en = 1'b1;
    idle(3);
    chk("R5", "preloaded bit 0", int'(sdata), int'(!pat(0)));
    idle(2);
    finish_run();
  end

endmodule